// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor port and a word-wide main-memory port. It holds 64 sets of two 16-word blocks. A processor access splits its 16-bit word address into a tag, a set index and a word offset. The block checks both ways of the indexed set in the same cycle, and a hit completes in that cycle. On a miss the controller picks a victim way. If that victim holds modified data, the controller first copies the victim block back to memory. It then reads the whole new block, one word per memory handshake, and only after that completes the access as a hit.

Stores follow a write-back, write-allocate policy. A store that misses first brings its block in and then changes the word inside the cache. Memory sees the new value only when that block is later evicted. A single LRU bit per set chooses the victim, and an empty way is always used first.

The processor holds its request and address stable until it sees `cpu_ready` high at a clock edge. The memory side holds its request and address stable until `mem_ack` pulses for one cycle.

Top module: `setassoc2_cache`

## Requirements
- R1: The word address is split as offset = bits [3:0], set = bits [9:4] and tag = bits [15:10]. Blocks whose block numbers (bits [15:4]) differ by a multiple of 64 share a set. Blocks in different sets never displace each other.
- R2: Two different blocks of one set can be resident together. After both are loaded, both hit without any memory traffic.
- R3: A hit raises `cpu_ready` in the same cycle as the request and issues no memory request. On a load, `cpu_rdata` carries the stored word in that cycle.
- R4: Reset clears every valid bit, so the first access to any block after reset misses. Coming out of reset, `cpu_ready` and `mem_req` are low.
- R5: A load miss reads all 16 words of its block, in ascending offset order starting at offset 0. Only then does it raise `cpu_ready`, returning the memory word.
- R6: A store miss loads the block as a read fill and then writes the word into the cache. No memory write takes place for that store, and a later load of the word returns the stored value.
- R7: When the victim is valid and modified, its 16 words are written to memory at the victim's own block address, in ascending offset order. These writes complete before any fill read starts.
- R8: A clean or invalid victim is discarded without any memory write.
- R9: An invalid way is always filled first. Otherwise the victim is the way of the set that was not accessed most recently.
- R10: While `mem_req` is high and `mem_ack` has not yet pulsed, `mem_addr` stays constant. Each `mem_ack` pulse transfers exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Word address: tag, set, offset |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes at this edge |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of a word transfer |

## Verification
A corrupted tag, valid bit or LRU bit shows up on the ports at the next access to that set. It appears as an unexpected miss (16 fill reads where none were due), a missing miss (a ready in cycle zero), or the wrong victim. A wrong victim is visible through the write-back count and the victim block address on `mem_addr`. A lost dirty bit or a wrong data-array write only appears later: the stored value comes back wrong after its block has been evicted and refetched. For that reason the sweep evicts and re-reads modified blocks in every set.

// File: rtl/c2w_pkg.sv
package c2w_pkg;

    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic hit;
        logic hit_way;
        logic victim_way;
        logic victim_dirty;
    } lookup_t;

    function automatic logic pick_victim(input logic vld0, input logic vld1, input logic lru);
        if (!vld0)      return 1'b0;
        else if (!vld1) return 1'b1;
        else            return lru;
    endfunction

endpackage

// File: rtl/c2w_tag_store.sv
module c2w_tag_store
    import c2w_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int SET_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             touch,
    input  logic             touch_way,
    input  logic             mark_dirty,
    input  logic             fill_done,
    input  logic             fill_way,
    output lookup_t          lk,
    output logic [TAG_W-1:0] victim_tag
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]  vld_q   [WAYS];
    logic [SETS-1:0]  dirty_q [WAYS];
    logic [TAG_W-1:0] tag_q   [WAYS][SETS];
    logic [SETS-1:0]  lru_q;
    logic [WAYS-1:0]  way_hit;
    logic             vict;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = vld_q[w][set_idx] && (tag_q[w][set_idx] == tag_in);
    end

    assign vict = pick_victim(vld_q[0][set_idx], vld_q[1][set_idx], lru_q[set_idx]);

    always_comb begin
        lk.hit          = |way_hit;
        lk.hit_way      = way_hit[1];
        lk.victim_way   = vict;
        lk.victim_dirty = vld_q[vict][set_idx] && dirty_q[vict][set_idx];
        victim_tag      = tag_q[vict][set_idx];
    end

    // valid, dirty and LRU bits: reset clears them (R4)
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) begin
                vld_q[w]   <= '0;
                dirty_q[w] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (touch) begin
                lru_q[set_idx] <= ~touch_way;
                if (mark_dirty) dirty_q[touch_way][set_idx] <= 1'b1;
            end
            if (fill_done) begin
                vld_q[fill_way][set_idx]   <= 1'b1;
                dirty_q[fill_way][set_idx] <= 1'b0;
                lru_q[set_idx]             <= ~fill_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_done) tag_q[fill_way][set_idx] <= tag_in;
    end

    // R2
    hit_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));

    // R7
    dirty_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (touch && mark_dirty) |=> dirty_q[$past(touch_way)][$past(set_idx)]);

endmodule

// File: rtl/c2w_data_store.sv
module c2w_data_store #(
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              a_way,
    input  logic [SET_W-1:0]  a_set,
    input  logic [OFF_W-1:0]  a_off,
    output logic [DATA_W-1:0] a_data,
    input  logic              b_way,
    input  logic [SET_W-1:0]  b_set,
    input  logic [OFF_W-1:0]  b_off,
    output logic [DATA_W-1:0] b_data
);
    localparam int IDX_W = 1 + SET_W + OFF_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) words_q[{wr_way, wr_set, wr_off}] <= wr_data;
    end

    assign a_data = words_q[{a_way, a_set, a_off}];
    assign b_data = words_q[{b_way, b_set, b_off}];

endmodule

// File: rtl/c2w_miss_seq.sv
module c2w_miss_seq
    import c2w_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int SET_W = 6,
    parameter int OFF_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_miss,
    input  logic                         victim_dirty,
    input  logic                         victim_way,
    input  logic [TAG_W-1:0]             victim_tag,
    input  logic [TAG_W-1:0]             req_tag,
    input  logic [SET_W-1:0]             req_set,
    input  logic                         mem_ack,
    output seq_state_e                   state,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [TAG_W+SET_W+OFF_W-1:0] mem_addr,
    output logic [OFF_W-1:0]             word_idx,
    output logic                         slot_way,
    output logic                         fill_wr,
    output logic                         fill_done
);
    localparam logic [OFF_W-1:0] LAST = '1;

    seq_state_e       state_q;
    logic [OFF_W-1:0] cnt_q;
    logic             way_q;
    logic [TAG_W-1:0] vtag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOKUP;
            cnt_q   <= '0;
            way_q   <= 1'b0;
            vtag_q  <= '0;
        end else begin
            unique case (state_q)
                ST_LOOKUP: if (start_miss) begin
                    cnt_q   <= '0;
                    way_q   <= victim_way;
                    vtag_q  <= victim_tag;
                    state_q <= victim_dirty ? ST_EVICT : ST_REFILL;
                end
                ST_EVICT: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_REFILL;
                end
                ST_REFILL: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_LOOKUP;
                end
                default: state_q <= ST_LOOKUP;
            endcase
        end
    end

    always_comb begin
        state     = state_q;
        mem_req   = (state_q == ST_EVICT) || (state_q == ST_REFILL);
        mem_we    = (state_q == ST_EVICT);
        mem_addr  = (state_q == ST_EVICT) ? {vtag_q, req_set, cnt_q}
                                          : {req_tag, req_set, cnt_q};
        word_idx  = cnt_q;
        slot_way  = way_q;
        fill_wr   = (state_q == ST_REFILL) && mem_ack;
        fill_done = fill_wr && (cnt_q == LAST);
    end

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R7
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVICT) |=> (state_q == ST_EVICT || state_q == ST_REFILL));

endmodule

// File: rtl/setassoc2_cache.sv
module setassoc2_cache
    import c2w_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 32,
    localparam int ADDR_W = TAG_W + SET_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [TAG_W-1:0] a_tag;
    logic [SET_W-1:0] a_set;
    logic [OFF_W-1:0] a_off;

    assign {a_tag, a_set, a_off} = cpu_addr;

    lookup_t          lk;
    logic [TAG_W-1:0] vtag;
    seq_state_e       st;
    logic [OFF_W-1:0] widx;
    logic             sway;
    logic             fill_wr, fill_done;
    logic             in_lookup, start_miss;

    assign in_lookup  = (st == ST_LOOKUP);
    assign cpu_ready  = in_lookup && cpu_req && lk.hit;
    assign start_miss = in_lookup && cpu_req && !lk.hit;

    c2w_tag_store #(.TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .set_idx    (a_set),
        .tag_in     (a_tag),
        .touch      (cpu_ready),
        .touch_way  (lk.hit_way),
        .mark_dirty (cpu_we),
        .fill_done  (fill_done),
        .fill_way   (sway),
        .lk         (lk),
        .victim_tag (vtag)
    );

    c2w_miss_seq #(.TAG_W(TAG_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_miss   (start_miss),
        .victim_dirty (lk.victim_dirty),
        .victim_way   (lk.victim_way),
        .victim_tag   (vtag),
        .req_tag      (a_tag),
        .req_set      (a_set),
        .mem_ack      (mem_ack),
        .state        (st),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .word_idx     (widx),
        .slot_way     (sway),
        .fill_wr      (fill_wr),
        .fill_done    (fill_done)
    );

    logic              wr_en, wr_way;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_data;

    always_comb begin
        wr_en   = 1'b0;
        wr_way  = sway;
        wr_off  = widx;
        wr_data = mem_rdata;
        if (cpu_ready && cpu_we) begin
            wr_en   = 1'b1;
            wr_way  = lk.hit_way;
            wr_off  = a_off;
            wr_data = cpu_wdata;
        end else if (fill_wr) begin
            wr_en = 1'b1;
        end
    end

    c2w_data_store #(.SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_way  (wr_way),
        .wr_set  (a_set),
        .wr_off  (wr_off),
        .wr_data (wr_data),
        .a_way   (lk.hit_way),
        .a_set   (a_set),
        .a_off   (a_off),
        .a_data  (cpu_rdata),
        .b_way   (sway),
        .b_set   (a_set),
        .b_off   (widx),
        .b_data  (mem_wdata)
    );

    // R5
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> lk.hit);

    // R3
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !mem_req);

endmodule

// File: tb/setassoc2_cache_test.sv
module setassoc2_cache_test;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2 clk = ~clk;

    setassoc2_cache uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [31:0] mem_arr [int];
    logic [31:0] gold    [int];

    function automatic logic [31:0] init_word(input int a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    function automatic logic [31:0] mem_rd(input int a);
        return mem_arr.exists(a) ? mem_arr[a] : init_word(a);
    endfunction

    function automatic logic [31:0] gold_rd(input int a);
        return gold.exists(a) ? gold[a] : init_word(a);
    endfunction

    // memory model: word transfers with fixed latency, logs order and stability
    int rd_n = 0, wr_n = 0, ord_err = 0, stab_err = 0;
    int exp_rd_blk = 0, exp_wr_blk = 0;
    int lat = 0;
    logic [15:0] held = '0;

    always @(posedge clk) begin
        if (rst) begin
            lat <= 0;
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat == 0) held = mem_addr;
                else if (mem_addr != held) stab_err++;
                if (lat == LAT) begin
                    lat <= 0;
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        if (int'(mem_addr[15:4]) != exp_wr_blk || int'(mem_addr[3:0]) != wr_n % 16
                            || rd_n != 0) ord_err++;
                        mem_arr[int'(mem_addr)] = mem_wdata;
                        wr_n++;
                    end else begin
                        if (int'(mem_addr[15:4]) != exp_rd_blk || int'(mem_addr[3:0]) != rd_n % 16)
                            ord_err++;
                        mem_rdata <= mem_rd(int'(mem_addr));
                        rd_n++;
                    end
                end else begin
                    lat <= lat + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // bench-side cache model from the requirements
    bit       m_v [2][64];
    bit       m_d [2][64];
    bit [5:0] m_t [2][64];
    bit       m_lru [64];

    task automatic access(input bit we, input bit [5:0] tg, input bit [5:0] st,
                          input bit [3:0] of, input logic [31:0] wd, input string rq);
        int  a = int'({tg, st, of});
        bit  hit = 0, hw = 0, vw, wb;
        int  cyc = 0;
        logic [31:0] got;
        for (int w = 0; w < 2; w++)
            if (m_v[w][st] && m_t[w][st] == tg) begin hit = 1; hw = w[0]; end
        vw = !m_v[0][st] ? 1'b0 : (!m_v[1][st] ? 1'b1 : m_lru[st]);
        wb = !hit && m_v[vw][st] && m_d[vw][st];
        exp_rd_blk = int'({tg, st});
        exp_wr_blk = int'({m_t[vw][st], st});
        rd_n = 0; wr_n = 0; ord_err = 0; stab_err = 0;

        cpu_req = 1'b1; cpu_we = we; cpu_addr = 16'(a); cpu_wdata = wd;
        #1;
        while (!cpu_ready && cyc < 3000) begin
            @(negedge clk); #1;
            cyc++;
        end
        got = cpu_rdata;
        chk(cpu_ready == 1'b1, rq, "ready seen", 32'(cpu_ready), 32'd1);
        if (hit) chk(cyc == 0, rq, "hit latency", 32'(cyc), 32'd0);
        if (!we) chk(got == gold_rd(a), rq, "load data", got, gold_rd(a));
        chk(rd_n == (hit ? 0 : 16), rq, "fill reads", 32'(rd_n), hit ? 32'd0 : 32'd16);
        chk(wr_n == (wb ? 16 : 0), rq, "write-backs", 32'(wr_n), wb ? 32'd16 : 32'd0);
        chk(ord_err == 0, "R5/R7", "word order", 32'(ord_err), 32'd0);
        chk(stab_err == 0, "R10", "addr hold", 32'(stab_err), 32'd0);

        if (we) gold[a] = wd;
        if (hit) begin
            m_lru[st] = ~hw;
            if (we) m_d[hw][st] = 1'b1;
        end else begin
            m_v[vw][st] = 1'b1; m_t[vw][st] = tg; m_d[vw][st] = we; m_lru[st] = ~vw;
        end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < 64; s++) begin
            m_v[0][s] = 0; m_v[1][s] = 0; m_d[0][s] = 0; m_d[1][s] = 0; m_lru[s] = 0;
            m_t[0][s] = 0; m_t[1][s] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R4: idle after reset
        chk(cpu_ready == 1'b0, "R4", "ready after reset", 32'(cpu_ready), 32'd0);
        chk(mem_req == 1'b0, "R4", "mem_req after reset", 32'(mem_req), 32'd0);
        @(negedge clk);

        for (int s = 0; s < 64; s++) begin
            access(0, 6'd1, 6'(s), 4'(s % 16), '0, "R4 R5");
            access(0, 6'd1, 6'(s), 4'((s + 5) % 16), '0, "R3");
            access(1, 6'd2, 6'(s), 4'd3, 32'hC0DE_0000 + 32'(s), "R6 R9");
            access(0, 6'd2, 6'(s), 4'd3, '0, "R6");
            access(0, 6'd1, 6'(s), 4'd7, '0, "R2");
            access(0, 6'd3, 6'(s), 4'd0, '0, "R7 R9");
            access(0, 6'd2, 6'(s), 4'd3, '0, "R8 R7");
        end
        // R1: other sets' traffic left every set's content intact
        for (int s = 0; s < 64; s++) begin
            access(0, 6'd3, 6'(s), 4'd15, '0, "R1");
            access(1, 6'd2, 6'(s), 4'd9, 32'hBEEF_0000 + 32'(s), "R1");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule